// File: doc/BRIEF.md
# Modem Ring and Powerdown Conditioner

This block sits between a host-side card controller and a companion modem chipset. It turns a raw ring-detect line and a few control bits into the signals that the modem and the host side expect. A ring signal toggles at roughly 20 Hz while the line rings and rests low otherwise. The block stretches those toggles into a steady "ringing" level. It drives two ring outputs with different shapes: an inverting one that stays dark until a settling delay has passed after wake-up, and a following one that marks each powerdown entry and exit with a rising edge. It also produces the modem powerdown and idle controls, a selectable status-change output, and a gated speaker pass-through.

The raw ring input is asynchronous. It passes through a synchroniser before any decision is made. The powerdown request is the OR of the software powerdown bit and a disabled modem function. The settling delay, the stretch timeout and the marker pulse width are parameters in clock cycles. At 20 MHz the defaults give about 12 ms, 75 ms and 4 clocks. Every output is registered. The reset is asynchronous on assertion and is released internally two clocks after `rst_ni` rises.

Below, "s" means `ring_raw_i` delayed by SYNC_STAGES clocks (the synchronised ring level). "Ringing" means that s changed in the current cycle or within the last HOLD_CYC cycles.

Top module: `mdm_ring_pwr`

## Requirements
- R1: One clock after `pd_bit_i`=1 or `fn_en_i`=0 is sampled, `mdm_pd_no` is 0 and `mdm_idle_o` is 1. One clock after `pd_bit_i`=0 with `fn_en_i`=1 is sampled, they are 1 and 0.
- R2: `ring_a_o` is 0 in every cycle that follows a cycle in which `mdm_idle_o` was 1.
- R3: After `mdm_idle_o` falls, `ring_a_o` stays 0 for WAKE_CYC further cycles and may first be non-zero WAKE_CYC+1 cycles after the fall. A new powerdown request restarts this delay.
- R4: Once awake and while ringing, `ring_a_o` is the complement of s, one clock later.
- R5: Ringing holds for HOLD_CYC cycles after the last change of s and then ends. Awake and not ringing, `ring_a_o` is 1, even if `ring_raw_i` has stayed high.
- R6: While powered up and no marker sequence is running, `ring_b_o` equals s, one clock later.
- R7: On powerdown entry, `ring_b_o` is 0 for PULSE_CYC cycles and then 1 for the rest of the powerdown.
- R8: On powerdown exit, `ring_b_o` is 0 for PULSE_CYC cycles, then 1 for PULSE_CYC cycles, and then returns to R6. An exit sequence that has started runs to its end before a new entry is acted on.
- R9: `status_chg_o` shows, one clock later, the ringing status when `ring_en_i`=1 and `mdm_chg_i` when `ring_en_i`=0.
- R10: `spk_oe_o` equals `audio_en_i` one clock later. `spk_o` equals `spk_i` one clock later when enabled and is 0 otherwise.
- R11: While `rst_ni` is low and for two clocks after it rises, the outputs read as follows: `mdm_pd_no`=0, `mdm_idle_o`=1, `ring_a_o`=0, `ring_b_o`=1, `status_chg_o`=0, `spk_o`=0, `spk_oe_o`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ring_raw_i | input | 1 | Raw ring-detect line from the modem, asynchronous |
| pd_bit_i | input | 1 | Software powerdown bit |
| fn_en_i | input | 1 | Modem function enabled |
| ring_en_i | input | 1 | Selects the ringing status onto `status_chg_o` |
| mdm_chg_i | input | 1 | Modem-changed status bit |
| audio_en_i | input | 1 | Speaker pass-through enable |
| spk_i | input | 1 | Digitised speaker signal from the modem |
| ring_a_o | output | 1 | Inverting ring output, delayed after wake-up |
| ring_b_o | output | 1 | Following ring output with powerdown markers |
| mdm_pd_no | output | 1 | Modem powerdown, active low |
| mdm_idle_o | output | 1 | Modem idle, active high |
| status_chg_o | output | 1 | Status-changed output |
| spk_o | output | 1 | Speaker output data |
| spk_oe_o | output | 1 | Speaker output enable; 0 means the pad floats |

## Verification
The bench targets four corner cases.

- A ring burst that stops with the line held high. A design that reads the ringing level from the raw input instead of from the stretch timer would keep `ring_a_o` low forever.
- The exact wake-up cycle of `ring_a_o`. A powerdown request arriving during the wake-up delay must restart it, so an off-by-one counter or a counter that is not reloaded is seen at once.
- A powerdown request only one cycle long. It must still produce both markers on `ring_b_o` in full, which exposes a shaper that drops or truncates a sequence.
- Ringing while powered down, and both settings of the status selector, which catch a design that gates the stretcher with the power state or swaps the status sources.

// File: rtl/mrp_pkg.sv
package mrp_pkg;

  // States of the ring-B shaper
  typedef enum logic [2:0] {
    BS_TRACK    = 3'd0,  // powered up, following the ring level
    BS_ENTER_LO = 3'd1,  // entry marker, low phase
    BS_PARK     = 3'd2,  // powered down, held high
    BS_LEAVE_LO = 3'd3,  // exit marker, low phase
    BS_LEAVE_HI = 3'd4   // exit marker, high phase
  } bshape_st_e;

endpackage

// File: rtl/mrp_sync.sv
module mrp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/mrp_stretch.sv
module mrp_stretch #(
  parameter int unsigned HOLD_CYC = 1500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ring_i,
  output logic ringing_o
);

  localparam int unsigned CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD_CYC);

  logic          ring_q;
  logic          toggle;
  logic          cnt_en;
  logic [CW-1:0] cnt_q, cnt_d;

  // next state
  always_comb begin
    toggle = ring_i ^ ring_q;
    cnt_en = toggle || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (toggle)              cnt_d = LOAD;
    else if (cnt_q != '0)    cnt_d = cnt_q - CW'(1);
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ring_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      ring_q <= ring_i;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  // a change counts as ringing in its own cycle, so nothing lags the edge
  assign ringing_o = toggle || (cnt_q != '0);

  AST_STRETCH_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(toggle) |-> ringing_o); // R5

endmodule

// File: rtl/mrp_wake.sv
module mrp_wake #(
  parameter int unsigned WAKE_CYC = 240000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_i,
  output logic live_o
);

  localparam int unsigned CW = $clog2(WAKE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(WAKE_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          live_q, live_d;
  logic          upd_en;

  // next state
  always_comb begin
    cnt_d  = cnt_q;
    live_d = live_q;
    upd_en = pd_i || !live_q;
    if (pd_i) begin
      cnt_d  = LOAD;
      live_d = 1'b0;
    end else if (!live_q) begin
      if (cnt_q != '0) cnt_d = cnt_q - CW'(1);
      live_d = (cnt_q <= CW'(1));
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= LOAD;
      live_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q  <= cnt_d;
      live_q <= live_d;
    end
  end

  assign live_o = live_q;

  AST_WAKE_AFTER_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(live_o) |-> !$past(pd_i)); // R3

  AST_WAKE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> !live_o); // R2

endmodule

// File: rtl/mrp_bshape.sv
module mrp_bshape #(
  parameter int unsigned PULSE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_i,
  input  logic ring_i,
  output logic ring_b_o
);

  localparam int unsigned CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(PULSE_CYC - 1);

  mrp_pkg::bshape_st_e st_q, st_d;
  logic [CW-1:0]       cnt_q, cnt_d;
  logic                out_q, out_d;

  // next state
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    out_d = out_q;
    case (st_q)
      mrp_pkg::BS_TRACK: begin
        if (pd_i) begin
          st_d  = mrp_pkg::BS_ENTER_LO;
          cnt_d = LAST;
          out_d = 1'b0;
        end else begin
          out_d = ring_i;
        end
      end
      mrp_pkg::BS_ENTER_LO: begin
        if (cnt_q == '0) begin
          st_d  = mrp_pkg::BS_PARK;
          out_d = 1'b1;
        end else begin
          cnt_d = cnt_q - CW'(1);
          out_d = 1'b0;
        end
      end
      mrp_pkg::BS_PARK: begin
        if (!pd_i) begin
          st_d  = mrp_pkg::BS_LEAVE_LO;
          cnt_d = LAST;
          out_d = 1'b0;
        end else begin
          out_d = 1'b1;
        end
      end
      mrp_pkg::BS_LEAVE_LO: begin
        if (cnt_q == '0) begin
          st_d  = mrp_pkg::BS_LEAVE_HI;
          cnt_d = LAST;
          out_d = 1'b1;
        end else begin
          cnt_d = cnt_q - CW'(1);
          out_d = 1'b0;
        end
      end
      mrp_pkg::BS_LEAVE_HI: begin
        if (cnt_q == '0) begin
          st_d  = mrp_pkg::BS_TRACK;
          out_d = ring_i;
        end else begin
          cnt_d = cnt_q - CW'(1);
          out_d = 1'b1;
        end
      end
      default: begin
        st_d  = mrp_pkg::BS_PARK;
        cnt_d = '0;
        out_d = 1'b1;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= mrp_pkg::BS_PARK;
      cnt_q <= '0;
      out_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign ring_b_o = out_q;

  AST_B_ENTRY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == mrp_pkg::BS_TRACK && pd_i) |=> !ring_b_o); // R7

  AST_B_LEAVE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == mrp_pkg::BS_LEAVE_LO) |-> !ring_b_o); // R8

  AST_B_TRACK_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == mrp_pkg::BS_TRACK && $past(st_q) == mrp_pkg::BS_TRACK)
      |-> (ring_b_o == $past(ring_i))); // R6

endmodule

// File: rtl/mdm_ring_pwr.sv
module mdm_ring_pwr #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WAKE_CYC    = 240000,
  parameter int unsigned HOLD_CYC    = 1500000,
  parameter int unsigned PULSE_CYC   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ring_raw_i,
  input  logic pd_bit_i,
  input  logic fn_en_i,
  input  logic ring_en_i,
  input  logic mdm_chg_i,
  input  logic audio_en_i,
  input  logic spk_i,
  output logic ring_a_o,
  output logic ring_b_o,
  output logic mdm_pd_no,
  output logic mdm_idle_o,
  output logic status_chg_o,
  output logic spk_o,
  output logic spk_oe_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe <= '0;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  logic ring_s;
  logic ringing;
  logic live;
  logic pd_req;
  logic pd_q;
  logic ring_a_q, ring_a_d;
  logic stat_q, stat_d;
  logic spk_q, spk_d;
  logic spk_oe_q;

  mrp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_i),
    .d_i   (ring_raw_i),
    .q_o   (ring_s)
  );

  mrp_stretch #(.HOLD_CYC(HOLD_CYC)) u_stretch (
    .clk_i    (clk_i),
    .rst_ni   (rst_i),
    .ring_i   (ring_s),
    .ringing_o(ringing)
  );

  mrp_wake #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk_i (clk_i),
    .rst_ni(rst_i),
    .pd_i  (pd_q),
    .live_o(live)
  );

  mrp_bshape #(.PULSE_CYC(PULSE_CYC)) u_bshape (
    .clk_i   (clk_i),
    .rst_ni  (rst_i),
    .pd_i    (pd_q),
    .ring_i  (ring_s),
    .ring_b_o(ring_b_o)
  );

  // next state
  always_comb begin
    pd_req = pd_bit_i || !fn_en_i;
    if (live && !pd_q) ring_a_d = ringing ? !ring_s : 1'b1;
    else               ring_a_d = 1'b0;
    stat_d = ring_en_i ? ringing : mdm_chg_i;
    spk_d  = audio_en_i && spk_i;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_i) begin
    if (!rst_i) begin
      pd_q     <= 1'b1;
      ring_a_q <= 1'b0;
      stat_q   <= 1'b0;
      spk_q    <= 1'b0;
      spk_oe_q <= 1'b0;
    end else begin
      pd_q     <= pd_req;
      ring_a_q <= ring_a_d;
      stat_q   <= stat_d;
      spk_q    <= spk_d;
      spk_oe_q <= audio_en_i;
    end
  end

  assign mdm_pd_no    = !pd_q;
  assign mdm_idle_o   = pd_q;
  assign ring_a_o     = ring_a_q;
  assign status_chg_o = stat_q;
  assign spk_o        = spk_q;
  assign spk_oe_o     = spk_oe_q;

  AST_PD_TRACK: assert property (@(posedge clk_i) disable iff (!rst_i)
    (pd_bit_i || !fn_en_i) |=> mdm_idle_o); // R1

  AST_A_DARK_IN_PD: assert property (@(posedge clk_i) disable iff (!rst_i)
    mdm_idle_o |=> !ring_a_o); // R2

  AST_SPK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_i)
    !spk_oe_o |-> !spk_o); // R10

endmodule

// File: tb/mdm_ring_pwr_tb.sv
module mdm_ring_pwr_tb;

  localparam int SYNC  = 2;
  localparam int WAKE  = 20;
  localparam int HOLD  = 30;
  localparam int PULSE = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, ring_raw, pd_bit, fn_en, ring_en, chg, audio, spk;
  logic ring_a, ring_b, pd_n, idle, stat, spk_out, spk_oe;

  mdm_ring_pwr #(
    .SYNC_STAGES(SYNC), .WAKE_CYC(WAKE), .HOLD_CYC(HOLD), .PULSE_CYC(PULSE)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ring_raw_i(ring_raw), .pd_bit_i(pd_bit),
    .fn_en_i(fn_en), .ring_en_i(ring_en), .mdm_chg_i(chg), .audio_en_i(audio),
    .spk_i(spk), .ring_a_o(ring_a), .ring_b_o(ring_b), .mdm_pd_no(pd_n),
    .mdm_idle_o(idle), .status_chg_o(stat), .spk_o(spk_out), .spk_oe_o(spk_oe)
  );

  int n_run  = 0;
  int n_fail = 0;
  bit chk_on = 1'b0;

  // behavioural reference: ring history, time stamps and phase counters
  bit    hist [0:SYNC];
  int    edge_no, last_tog, up_cnt, rel_cnt, bph, bcnt;
  bit    pd_prev, in_rst;
  bit    e_pd_n, e_idle, e_a, e_b, e_st, e_spk, e_oe;
  string tag_a, tag_b;

  task automatic mdl_reset();
    for (int k = 0; k <= SYNC; k++) hist[k] = 1'b0;
    pd_prev = 1'b1; up_cnt = 0; last_tog = -1000000; bph = 2; bcnt = 0;
    e_pd_n = 1'b0; e_idle = 1'b1; e_a = 1'b0; e_b = 1'b1;
    e_st = 1'b0; e_spk = 1'b0; e_oe = 1'b0; in_rst = 1'b1;
  endtask

  always @(posedge clk) begin
    edge_no++;
    if (!rst_n) begin
      rel_cnt = 0;
      mdl_reset();
    end else if (rel_cnt < 2) begin
      rel_cnt++;
      mdl_reset();
    end else begin
      bit rs_b, ring_now, live_b, pdb;
      rs_b = hist[SYNC-1];
      if (hist[SYNC-1] != hist[SYNC]) last_tog = edge_no;
      ring_now = (edge_no - last_tog) <= HOLD;
      live_b   = up_cnt >= WAKE;
      pdb      = pd_prev;
      // ring A
      if (pdb)           begin e_a = 1'b0;  tag_a = "R2"; end
      else if (!live_b)  begin e_a = 1'b0;  tag_a = "R3"; end
      else if (ring_now) begin e_a = !rs_b; tag_a = "R4"; end
      else               begin e_a = 1'b1;  tag_a = "R5"; end
      if (pdb) up_cnt = 0;
      else if (up_cnt < WAKE) up_cnt++;
      // ring B phases: 0 track, 1 entry low, 2 parked, 3 exit low, 4 exit high
      case (bph)
        0: if (pdb) begin bph = 1; bcnt = PULSE - 1; e_b = 1'b0; end
           else e_b = rs_b;
        1: if (bcnt == 0) begin bph = 2; e_b = 1'b1; end
           else begin bcnt--; e_b = 1'b0; end
        2: if (!pdb) begin bph = 3; bcnt = PULSE - 1; e_b = 1'b0; end
           else e_b = 1'b1;
        3: if (bcnt == 0) begin bph = 4; bcnt = PULSE - 1; e_b = 1'b1; end
           else begin bcnt--; e_b = 1'b0; end
        default: if (bcnt == 0) begin bph = 0; e_b = rs_b; end
                 else begin bcnt--; e_b = 1'b1; end
      endcase
      tag_b = (bph == 0) ? "R6" : ((bph <= 2) ? "R7" : "R8");
      e_st    = ring_en ? ring_now : chg;
      e_spk   = audio && spk;
      e_oe    = audio;
      pd_prev = pd_bit || !fn_en;
      e_idle  = pd_prev;
      e_pd_n  = !pd_prev;
      for (int k = SYNC; k >= 1; k--) hist[k] = hist[k-1];
      hist[0] = ring_raw;
      in_rst  = 1'b0;
    end
  end

  task automatic chk(input string tag, input string nm, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at %0t: actual %b expected %b", tag, nm, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      chk(in_rst ? "R11" : "R1",  "mdm_pd_no",    pd_n,    e_pd_n);
      chk(in_rst ? "R11" : "R1",  "mdm_idle_o",   idle,    e_idle);
      chk(in_rst ? "R11" : tag_a, "ring_a_o",     ring_a,  e_a);
      chk(in_rst ? "R11" : tag_b, "ring_b_o",     ring_b,  e_b);
      chk(in_rst ? "R11" : "R9",  "status_chg_o", stat,    e_st);
      chk(in_rst ? "R11" : "R10", "spk_o",        spk_out, e_spk);
      chk(in_rst ? "R11" : "R10", "spk_oe_o",     spk_oe,  e_oe);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ring_burst(input int toggles, input int half);
    for (int i = 0; i < toggles; i++) begin
      ring_raw = ~ring_raw;
      cyc(half);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    edge_no = 0; rel_cnt = 0; mdl_reset();
    tag_a = "R2"; tag_b = "R7";
    rst_n = 1'b0; ring_raw = 1'b0; pd_bit = 1'b1; fn_en = 1'b1;
    ring_en = 1'b1; chg = 1'b0; audio = 1'b0; spk = 1'b0;
    cyc(3);
    chk_on = 1'b1;          // R11 reset values
    cyc(3);
    rst_n = 1'b1;
    cyc(6);
    pd_bit = 1'b0;          // R3 wake-up delay, R8 exit marker
    cyc(30);
    ring_burst(6, 8);       // R4 inversion, R6 following
    cyc(45);                // R5 timeout
    ring_burst(5, 7);       // ends with the line high
    cyc(45);                // R5 ring A high again while input high
    ring_raw = 1'b0;
    cyc(40);
    pd_bit = 1'b1;          // R7 entry marker, R2
    cyc(12);
    pd_bit = 1'b0;          // R8, R3
    cyc(30);
    fn_en = 1'b0;           // R1 disabled function, ringing while down
    ring_burst(4, 6);
    cyc(10);
    fn_en = 1'b1;
    cyc(10);
    pd_bit = 1'b1;          // R3 restart during wake-up delay
    cyc(5);
    pd_bit = 1'b0;
    cyc(35);
    ring_en = 1'b0;         // R9 status select
    chg = 1'b1;
    cyc(4);
    chg = 1'b0;
    ring_burst(2, 5);
    cyc(5);
    ring_en = 1'b1;
    cyc(40);
    audio = 1'b1;           // R10 speaker
    for (int i = 0; i < 8; i++) begin
      spk = ~spk;
      cyc(2);
    end
    audio = 1'b0;
    spk = 1'b1;
    cyc(4);
    spk = 1'b0;
    pd_bit = 1'b1;          // one-cycle request: R7 and R8 both complete
    cyc(1);
    pd_bit = 1'b0;
    cyc(30);
    pd_bit = 1'b1;          // ringing across powerdown exit
    ring_burst(3, 6);
    pd_bit = 1'b0;
    ring_burst(4, 6);
    cyc(45);
    chk_on = 1'b0;
    summary();
    $finish;
  end

endmodule